// File: doc/BRIEF.md
# Precharge-Cycled Parallel Memory Host Controller

This block sits between a simple synchronous host port and an asynchronous 32K x 8 nonvolatile memory. That memory starts each access on a falling chip enable and needs chip enable held high for a precharge interval before the next access. The host pulses a request with a write flag, an address and write data. The controller then runs one complete memory cycle: one cycle of address setup with chip enable high, an access window of fixed length with chip enable low, and a precharge window with chip enable high. A read returns its byte with a one-cycle done pulse. A write needs no polling and is complete when precharge starts.

Two write styles are supported, chosen per transaction by a configuration input sampled when the request is accepted. In the chip-enable-controlled style, write enable goes low in the setup cycle, before chip enable falls. In the write-enable-controlled style, the access opens like a read with output enable held high, and write enable falls a hold interval after chip enable. Access, setup, hold and precharge lengths are parameters in clock cycles. Reads and writes share the same timing.

Top module: `cemem_host_ctrl`

## Requirements
- R1: During and right after reset, chip enable, write enable and output enable are high (inactive), busy is low and done is low.
- R2: A request accepted while idle gives one cycle with chip enable high and the latched address on the address bus. Chip enable is then low for exactly T_ACC cycles, and the address bus holds the accepted address throughout.
- R3: After every access, chip enable stays high for at least T_PRE cycles before it falls again. This holds even for back-to-back accesses to the same address.
- R4: In a read, output enable is low and write enable is high for the whole access. The data bus is sampled on the clock edge that ends the access. done is high for exactly the first precharge cycle, and rdata_o then holds the byte stored at the address.
- R5: In a write with wstyle_i = 1 at acceptance (chip-enable-controlled), write enable is low from the setup cycle through the last access cycle. Output enable stays high.
- R6: In a write with wstyle_i = 0 at acceptance (write-enable-controlled), write enable is high for the first T_HOLD access cycles and low from access cycle T_HOLD (counted from 0) through the last one. Output enable stays high, and the controller never drives the data bus while output enable is low.
- R7: A write stores wdata_i at the addressed memory location. The data is driven at least T_SU cycles before the access ends.
- R8: busy_o is high from the cycle after acceptance until the last precharge cycle, and low when idle.
- R9: A request seen during precharge is held. Its setup cycle follows the last precharge cycle with no idle cycle in between.
- R10: A request seen during the setup cycle or the access is ignored and starts no transaction.
- R11: Write flag, address, write data and write style are captured at acceptance. Later changes on those inputs do not affect the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Transaction request |
| wr_i | input | 1 | 1 = write, 0 = read |
| wstyle_i | input | 1 | Write style: 1 = chip-enable-controlled, 0 = write-enable-controlled |
| addr_i | input | 15 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with done_o |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transaction in flight |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq | inout | 8 | Memory data bus, tri-state |

## Verification
The assertions assume the memory drives the data bus only while chip enable and output enable are low and write enable is high. They also assume the parameters satisfy T_ACC >= T_HOLD + T_SU, T_ACC >= 2 and T_PRE >= 1. The bench memory model obeys that drive rule by latching the cycle type at the falling chip enable and committing writes at the first rising strobe. Default parameters are used throughout. Host inputs change only between clock edges. Requests are sometimes held high across whole transactions and sometimes pulsed inside an access, so that the held and ignored paths both run.

// File: rtl/cemem_pkg.sv
// Shared types for the precharge-cycled memory host controller.
// Assumes nothing beyond a synchronous clock domain.
package cemem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_PRE    = 2'd3
    } cyc_state_e;
endpackage

// File: rtl/cemem_timer.sv
// Phase timer: counts cycles spent in the current controller phase.
// Assumes clear is asserted in the last cycle of the previous phase.
module cemem_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    // Restart on phase change, otherwise count up and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (count != '1) count <= count + 1'b1;
    end
endmodule

// File: rtl/cemem_dq_port.sv
// Data bus port: tri-state drive for writes and a capture register for reads.
// Assumes drive_en is asserted only while the memory's output enable is high.
module cemem_dq_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_en,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    output logic [DATA_W-1:0] rdata,
    inout  wire  [DATA_W-1:0] dq
);
    // Drive write data only when enabled, release the bus otherwise.
    assign dq = drive_en ? wdata : {DATA_W{1'bz}};

    // Sample the bus on the edge that closes a read access.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (capture) rdata <= dq;
    end

    // R6
    dq_no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> oe_n);
endmodule

// File: rtl/cemem_host_ctrl.sv
// Host controller for a chip-enable-cycled 32K x 8 memory. Runs setup, access
// and precharge phases per transaction and supports two write styles.
// Assumes T_ACC >= T_HOLD + T_SU, T_ACC >= 2 and T_PRE >= 1 (clock cycles).
module cemem_host_ctrl #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int T_ACC  = 4,
    parameter int T_SU   = 2,
    parameter int T_HOLD = 1,
    parameter int T_PRE  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic              wstyle_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq
);
    import cemem_pkg::*;

    localparam int CNT_MAX = (T_ACC > T_PRE) ? T_ACC : T_PRE;
    localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;
    localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(T_ACC - 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(T_PRE - 1);
    localparam logic [CNT_W-1:0] HOLD_C   = CNT_W'(T_HOLD);

    cyc_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt;
    logic              cur_wr, cur_sty;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_data;
    logic              pnd_v, pnd_wr, pnd_sty;
    logic [ADDR_W-1:0] pnd_addr;
    logic [DATA_W-1:0] pnd_data;
    logic              acc_end, pre_end, take_in, take_pnd, park;
    logic              in_acc, we_late, drive_en, capture;

    assign acc_end  = (state_q == ST_ACCESS) && (cnt == ACC_LAST);
    assign pre_end  = (state_q == ST_PRE) && (cnt == PRE_LAST);
    assign take_pnd = pre_end && pnd_v;
    assign take_in  = req_i && (((state_q == ST_IDLE)) || (pre_end && !pnd_v));
    assign park     = req_i && (state_q == ST_PRE) && !pre_end && !pnd_v;

    // Next phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (req_i) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ACCESS;
            ST_ACCESS: if (acc_end) state_d = ST_PRE;
            ST_PRE:    if (pre_end) state_d = (pnd_v || req_i) ? ST_SETUP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else state_q <= state_d;
    end

    cemem_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_d != state_q),
        .count (cnt)
    );

    // Capture the transaction in flight from the host or from the held slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_wr <= 1'b0; cur_sty <= 1'b0; cur_addr <= '0; cur_data <= '0;
        end else if (take_pnd) begin
            cur_wr <= pnd_wr; cur_sty <= pnd_sty; cur_addr <= pnd_addr; cur_data <= pnd_data;
        end else if (take_in) begin
            cur_wr <= wr_i; cur_sty <= wstyle_i; cur_addr <= addr_i; cur_data <= wdata_i;
        end
    end

    // Hold a request that arrives during precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnd_v <= 1'b0; pnd_wr <= 1'b0; pnd_sty <= 1'b0; pnd_addr <= '0; pnd_data <= '0;
        end else if (park) begin
            pnd_v <= 1'b1; pnd_wr <= wr_i; pnd_sty <= wstyle_i; pnd_addr <= addr_i; pnd_data <= wdata_i;
        end else if (pre_end) begin
            pnd_v <= 1'b0;
        end
    end

    // Strobe decode from phase, counter and the captured transaction.
    always_comb begin
        in_acc   = (state_q == ST_ACCESS);
        we_late  = in_acc && (cnt >= HOLD_C);
        mem_ce_n = !in_acc;
        mem_oe_n = !(in_acc && !cur_wr);
        mem_we_n = !(cur_wr && (cur_sty ? (in_acc || state_q == ST_SETUP) : we_late));
        drive_en = cur_wr && (cur_sty ? in_acc : we_late);
        capture  = acc_end && !cur_wr;
        mem_addr = cur_addr;
        busy_o   = (state_q != ST_IDLE);
    end

    // Completion pulse in the first precharge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else done_o <= acc_end;
    end

    cemem_dq_port #(.DATA_W(DATA_W)) u_dq (
        .clk      (clk),
        .rst_n    (rst_n),
        .drive_en (drive_en),
        .oe_n     (mem_oe_n),
        .wdata    (cur_data),
        .capture  (capture),
        .rdata    (rdata_o),
        .dq       (mem_dq)
    );

    // Checker state: lengths of the current chip-enable high and low runs.
    logic [CNT_W-1:0] hi_run, lo_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '1; lo_run <= '0;
        end else if (mem_ce_n) begin
            lo_run <= '0;
            if (hi_run != '1) hi_run <= hi_run + 1'b1;
        end else begin
            hi_run <= '0;
            if (lo_run != '1) lo_run <= lo_run + 1'b1;
        end
    end

    // R3
    precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |-> (hi_run >= CNT_W'(T_PRE)));
    // R2
    access_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (lo_run <= ACC_LAST));
    // R4
    done_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mem_ce_n && !$past(mem_ce_n)));
    // R8
    busy_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
endmodule

// File: tb/cemem_host_ctrl_tb.sv
module cemem_host_ctrl_tb;
    localparam int T_ACC = 4, T_SU = 2, T_HOLD = 1, T_PRE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, wr = 1'b0, sty = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0] wdat = '0;
    logic [7:0] rdata;
    logic done, busy, ce_n, we_n, oe_n;
    logic [14:0] maddr;
    wire  [7:0] dq;

    int checks = 0, fails = 0, cycles = 0;

    always #10 clk = ~clk;

    cemem_host_ctrl #(.T_ACC(T_ACC), .T_SU(T_SU), .T_HOLD(T_HOLD), .T_PRE(T_PRE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .wstyle_i(sty),
        .addr_i(addr), .wdata_i(wdat), .rdata_o(rdata), .done_o(done), .busy_o(busy),
        .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_addr(maddr), .mem_dq(dq)
    );

    // Behavioural memory: latch at falling CE, commit at first rising strobe.
    logic [7:0] marr [0:32767];
    logic [7:0] shadow [0:32767];
    logic [14:0] a_lat = '0;
    logic rd_lat = 1'b0;
    logic p_ce = 1'b1, p_we = 1'b1;
    logic [7:0] p_dq = '0;
    assign dq = (!ce_n && !oe_n && we_n && rd_lat) ? marr[a_lat] : 8'bz;

    always @(negedge clk) begin
        if (p_ce && !ce_n) begin a_lat = maddr; rd_lat = we_n; end
        if (!p_ce && !p_we && (ce_n || we_n)) marr[a_lat] = p_dq;
        p_ce = ce_n; p_we = we_n; p_dq = dq;
    end

    // Reference model: t = -1 idle, 0 setup, 1..T_ACC access, then precharge.
    int t = -1;
    logic m_wr = 0, m_sty = 0, p_v = 0, pw = 0, ps = 0;
    logic [14:0] m_addr = '0, pa = '0;
    logic [7:0] m_dat = '0, pd = '0, exp_rd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            t = -1; p_v = 0;
        end else if (t == -1) begin
            if (req) begin m_wr = wr; m_sty = sty; m_addr = addr; m_dat = wdat; t = 0; end
        end else if (t == T_ACC + T_PRE) begin
            if (p_v) begin m_wr = pw; m_sty = ps; m_addr = pa; m_dat = pd; p_v = 0; t = 0; end   // R9
            else if (req) begin m_wr = wr; m_sty = sty; m_addr = addr; m_dat = wdat; t = 0; end
            else t = -1;
        end else begin
            if (req && t > T_ACC && !p_v) begin pw = wr; ps = sty; pa = addr; pd = wdat; p_v = 1; end
            t = t + 1;   // requests in setup/access fall through unused: R10
            if (t == T_ACC + 1) begin
                if (m_wr) shadow[m_addr] = m_dat; else exp_rd = shadow[m_addr];
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag, input string nm);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0d", tag, nm, act, exp, t);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic acc, e_we;
            acc  = (t >= 1 && t <= T_ACC);
            e_we = !(m_wr && ((m_sty && t >= 0 && t <= T_ACC) || (!m_sty && acc && (t - 1) >= T_HOLD)));
            chk(ce_n, !acc, "R2/R3", "ce_n");
            chk(oe_n, !(acc && !m_wr), "R4", "oe_n");
            chk(we_n, e_we, m_sty ? "R5" : "R6", "we_n");
            chk(busy, t != -1, "R8", "busy");
            chk(done, t == T_ACC + 1, "R4", "done");
            if (acc) begin
                checks++;
                if (maddr !== m_addr) begin
                    fails++;
                    $display("FAIL R11 addr actual=%h expected=%h", maddr, m_addr);
                end
            end
            if (t == T_ACC + 1 && !m_wr) begin
                checks++;
                if (rdata !== exp_rd) begin
                    fails++;
                    $display("FAIL R4 rdata actual=%h expected=%h", rdata, exp_rd);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic pulse(input logic w, input logic s, input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        req = 1; wr = w; sty = s; addr = a; wdat = d;
        @(negedge clk);
        req = 0; wr = ~w; sty = ~s; addr = ~a; wdat = ~d;   // R11: scramble after acceptance
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (t != -1);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32768; i++) begin marr[i] = 8'h00; shadow[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ce_n, 1'b1, "R1", "ce_n"); chk(we_n, 1'b1, "R1", "we_n");
        chk(oe_n, 1'b1, "R1", "oe_n"); chk(busy, 1'b0, "R1", "busy");
        chk(done, 1'b0, "R1", "done");
        rst_n = 1;
        @(negedge clk);
        chk(busy, 1'b0, "R1", "busy_after");
        // R5, R7: chip-enable-controlled write then read back
        pulse(1, 1, 15'h0012, 8'hA5); wait_idle();
        pulse(0, 0, 15'h0012, 8'h00); wait_idle();
        // R6, R7: write-enable-controlled write at top address then read back
        pulse(1, 0, 15'h7FFF, 8'h3C); wait_idle();
        pulse(0, 1, 15'h7FFF, 8'h00); wait_idle();
        // R3, R9, R10: request held high across several back-to-back reads
        @(negedge clk);
        req = 1; wr = 0; sty = 0; addr = 15'h0012; wdat = 8'h00;
        repeat (30) @(negedge clk);
        req = 0;
        wait_idle();
        // R10: stray pulse during an access is ignored
        pulse(1, 1, 15'h0100, 8'h5A);
        repeat (2) @(negedge clk);
        req = 1; wr = 1; addr = 15'h0200; wdat = 8'hFF;
        @(negedge clk); req = 0;
        wait_idle();
        pulse(0, 0, 15'h0200, 8'h00); wait_idle();
        pulse(0, 0, 15'h0100, 8'h00); wait_idle();
        // R9: write request parked during precharge of a read
        pulse(0, 0, 15'h0012, 8'h00);
        repeat (T_ACC + 1) @(negedge clk);
        req = 1; wr = 1; sty = 0; addr = 15'h0300; wdat = 8'h77;
        @(negedge clk); req = 0;
        wait_idle();
        // Mixed styles over a spread of addresses
        for (int i = 0; i < 12; i++) begin
            logic [14:0] a;
            a = 15'(i * 2731 + 5);
            pulse(1, i[0], a, 8'(i * 37 + 1)); wait_idle();
            pulse(0, 0, a, 8'h00); wait_idle();
        end
        // R7: memory contents match the written data
        for (int i = 0; i < 12; i++) begin
            logic [14:0] a;
            a = 15'(i * 2731 + 5);
            checks++;
            if (marr[a] !== shadow[a]) begin
                fails++;
                $display("FAIL R7 mem[%h] actual=%h expected=%h", a, marr[a], shadow[a]);
            end
        end
        checks++;
        if (marr[15'h0300] !== 8'h77) begin
            fails++;
            $display("FAIL R9 mem[0300] actual=%h expected=77", marr[15'h0300]);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule